// File: doc/BRIEF.md
# Interleaved DRAM Line Fill Controller

This block fills one cache line from four word-interleaved DRAM banks that share an 8-byte data bus. A requester presents a 25-bit byte address together with a line-length flag and a page-mode flag. The controller splits the address into row, column and bank fields. It drives one row-strobe and one column-strobe pin per bank on a shared multiplexed address bus, and it returns the line as 8-byte beats in bank order 0, 1, 2, 3. It pulses done once the line is complete. Every count is in memory-bus cycles. The clock is the memory-bus clock.

A single row cycle opens the same row in all four banks at once. After that, each bank's beat takes one bus cycle on the shared bus. A 32-byte line needs one pass across the banks. A 64-byte line needs two passes. Without page mode, the second pass closes the row and opens it again once the full row cycle time has elapsed. With page mode, the row stays open and only a fresh column strobe is issued. The bank models inside the block return a data word derived from the address of each beat.

Top module: `linefill_ctrl`

## Requirements
- R1: While reset is asserted, and after it is released, the block is idle. In that state busy=0, all ras_n and cas_n bits are 1, beat_valid=0 and done=0.
- R2: Address fields are taken from req_addr as follows. The row is bits [24:15] and the column is bits [14:5]. Bits [4:0] are ignored. For a double line, column bit 0 is forced to 0 on the first pass and set to 1 on the second pass. While a row strobe opens a row, mem_addr carries the row. While column strobes are active, and during the page-mode column precharge cycle, mem_addr carries the column.
- R3: In the cycle after a request is accepted, all four ras_n go low together with mem_addr equal to the row. All four strobes of a kind always move together.
- R4: cas_n goes low T_RAC-T_CAC cycles after ras_n goes low. cas_n is never low while ras_n is high.
- R5: The first beat arrives T_CAC cycles after cas_n falls. The four beats then follow on consecutive cycles in bank order 0 to 3. Each beat_data word has the beat's byte address {row, column, bank, 3'b000}, zero-extended, in bits [63:32], and the bitwise inverse of that value in bits [31:0]. beat_data is 0 when no beat is valid.
- R6: done is high for exactly one cycle, in the cycle after the last beat. busy is high from the cycle after acceptance through the done cycle.
- R7: Without page mode, a double line raises all strobes after the first pass. It opens the row again max(T_RC, T_RAC+5) cycles after the first row strobe, and then repeats the full pass with the second column.
- R8: With page mode, a double line keeps ras_n low between passes. cas_n is high for one cycle, during which mem_addr carries the second column, and then goes low again. Beats follow T_CAC cycles after that second fall.
- R9: A request is accepted only when busy is 0. A request presented while busy is ignored. A request held high through done is accepted in the idle cycle that follows.
- R10: req_page has no effect on a single-length line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory-bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Line fill request |
| req_addr | input | 25 | Byte address of the line |
| req_double | input | 1 | 1 = 64-byte line (two passes) |
| req_page | input | 1 | 1 = keep the row open for the second pass |
| busy | output | 1 | A fill is in progress |
| ras_n | output | 4 | Row strobes, one per bank, active low |
| cas_n | output | 4 | Column strobes, one per bank, active low |
| mem_addr | output | 10 | Multiplexed row/column address |
| beat_valid | output | 1 | beat_data holds a beat |
| beat_data | output | 64 | One 8-byte beat |
| done | output | 1 | One-cycle pulse after the last beat |

## Verification
The bench builds the block with its default timing: row latency 3, column latency 2 and row cycle 8. With these values the row-to-column delay is one cycle, the non-page second pass passes through a single precharge cycle, and the page-mode pass shortens the double line by one cycle. This makes the difference between the two double-line schedules visible on every cycle. Addresses with ignored low bits set, all-ones and all-zero fields, and a request held through done let the model check field extraction, back-to-back acceptance and the rule that a request is ignored while the block is busy.

// File: rtl/lf_pkg.sv
package lf_pkg;
  localparam int NBANK     = 4;
  localparam int BANK_W    = 2;
  localparam int BUS_BYTES = 8;
  localparam int OFF_W     = 3;
  localparam int DATA_W    = 8 * BUS_BYTES;

  typedef enum logic [2:0] {
    S_IDLE  = 3'd0,
    S_RAS   = 3'd1,
    S_BURST = 3'd2,
    S_GAP   = 3'd3,
    S_PCH   = 3'd4,
    S_DONE  = 3'd5
  } fill_state_t;
endpackage

// File: rtl/lf_bank.sv
module lf_bank
  import lf_pkg::*;
#(
  parameter int ROW_W   = 10,
  parameter int COL_W   = 10,
  parameter int MA_W    = 10,
  parameter int T_CAC   = 2,
  parameter int BANK_ID = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ras_n,
  input  logic              cas_n,
  input  logic [MA_W-1:0]   mem_addr,
  output logic              data_ok,
  output logic [DATA_W-1:0] data
);
  localparam int ADDR_W = ROW_W + COL_W + BANK_W + OFF_W;
  localparam int HALF   = DATA_W / 2;
  localparam int CMAX   = T_CAC + NBANK;
  localparam int CW     = $clog2(CMAX + 1);

  logic             ras_prev_q, cas_prev_q;
  logic [ROW_W-1:0] row_q;
  logic [COL_W-1:0] col_q;
  logic [CW-1:0]    cnt_q, cnt_d;
  logic             row_fall, col_fall;

  assign row_fall = !ras_n && ras_prev_q;
  assign col_fall = !cas_n && cas_prev_q;

  always_comb begin
    cnt_d = cnt_q;
    if (cas_n)                         cnt_d = '0;
    else if (col_fall)                 cnt_d = CW'(1);
    else if (cnt_q != CW'(CMAX))       cnt_d = cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ras_prev_q <= 1'b1;
      cas_prev_q <= 1'b1;
      cnt_q      <= '0;
      row_q      <= '0;
      col_q      <= '0;
    end else begin
      ras_prev_q <= ras_n;
      cas_prev_q <= cas_n;
      cnt_q      <= cnt_d;
      if (row_fall) row_q <= mem_addr[ROW_W-1:0];
      if (col_fall) col_q <= mem_addr[COL_W-1:0];
    end
  end

  logic [ADDR_W-1:0] byte_addr;
  assign byte_addr = {row_q, col_q, BANK_W'(BANK_ID), {OFF_W{1'b0}}};
  assign data_ok   = !cas_n && (cnt_q >= CW'(T_CAC));
  assign data      = {HALF'(byte_addr), ~HALF'(byte_addr)};

  assert_col_inside_row_R4: assert property (@(posedge clk) disable iff (!rst_n)
    col_fall |-> !ras_n);
endmodule

// File: rtl/lf_sequencer.sv
module lf_sequencer
  import lf_pkg::*;
#(
  parameter int ROW_W = 10,
  parameter int COL_W = 10,
  parameter int MA_W  = 10,
  parameter int T_RAC = 3,
  parameter int T_CAC = 2,
  parameter int T_RC  = 8
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic                                  req_valid,
  input  logic [ROW_W+COL_W+BANK_W+OFF_W-1:0]   req_addr,
  input  logic                                  req_double,
  input  logic                                  req_page,
  output logic                                  busy,
  output logic [NBANK-1:0]                      ras_n,
  output logic [NBANK-1:0]                      cas_n,
  output logic [MA_W-1:0]                       mem_addr,
  output logic                                  beat_valid,
  output logic [BANK_W-1:0]                     beat_bank,
  output logic                                  done
);
  localparam int T_RCD     = T_RAC - T_CAC;
  localparam int BURST_LEN = T_CAC + NBANK;
  localparam int GAP_RAW   = T_RC - T_RAC - NBANK;
  localparam int GAP       = (GAP_RAW > 1) ? GAP_RAW : 1;
  localparam int M1        = (T_RCD > BURST_LEN) ? T_RCD : BURST_LEN;
  localparam int CNT_MAX   = (M1 > GAP) ? M1 : GAP;
  localparam int CW        = $clog2(CNT_MAX + 1);
  localparam int COL_LSB   = OFF_W + BANK_W;
  localparam int ROW_LSB   = COL_LSB + COL_W;

  fill_state_t      st_q, st_d;
  logic [CW-1:0]    cnt_q, cnt_d;
  logic [ROW_W-1:0] row_q;
  logic [COL_W-1:0] col_q, col_d;
  logic             dbl_q, page_q, pass2_q, pass2_d;
  logic             load_req, col_step;

  always_comb begin
    st_d     = st_q;
    cnt_d    = cnt_q;
    pass2_d  = pass2_q;
    load_req = 1'b0;
    col_step = 1'b0;
    unique case (st_q)
      S_IDLE: if (req_valid) begin
        load_req = 1'b1;
        pass2_d  = 1'b0;
        st_d     = S_RAS;
        cnt_d    = '0;
      end
      S_RAS: if (cnt_q == CW'(T_RCD - 1)) begin
        st_d  = S_BURST;
        cnt_d = '0;
      end else cnt_d = cnt_q + CW'(1);
      S_BURST: if (cnt_q == CW'(BURST_LEN - 1)) begin
        cnt_d = '0;
        if (dbl_q && !pass2_q) begin
          pass2_d  = 1'b1;
          col_step = 1'b1;
          st_d     = page_q ? S_PCH : S_GAP;
        end else st_d = S_DONE;
      end else cnt_d = cnt_q + CW'(1);
      S_GAP: if (cnt_q == CW'(GAP - 1)) begin
        st_d  = S_RAS;
        cnt_d = '0;
      end else cnt_d = cnt_q + CW'(1);
      S_PCH:  st_d = S_BURST;
      S_DONE: st_d = S_IDLE;
      default: st_d = S_IDLE;
    endcase
  end

  always_comb begin
    col_d = col_q;
    if (load_req) begin
      col_d = req_addr[COL_LSB +: COL_W];
      if (req_double) col_d[0] = 1'b0;
    end else if (col_step) col_d[0] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= S_IDLE;
      cnt_q   <= '0;
      pass2_q <= 1'b0;
      row_q   <= '0;
      col_q   <= '0;
      dbl_q   <= 1'b0;
      page_q  <= 1'b0;
    end else begin
      st_q    <= st_d;
      cnt_q   <= cnt_d;
      pass2_q <= pass2_d;
      if (load_req || col_step) col_q <= col_d;
      if (load_req) begin
        row_q  <= req_addr[ROW_LSB +: ROW_W];
        dbl_q  <= req_double;
        page_q <= req_page;
      end
    end
  end

  logic          row_open, col_open;
  logic [CW-1:0] beat_idx;
  assign row_open   = (st_q == S_RAS) || (st_q == S_BURST) || (st_q == S_PCH);
  assign col_open   = (st_q == S_BURST);
  assign ras_n      = row_open ? '0 : '1;
  assign cas_n      = col_open ? '0 : '1;
  assign beat_idx   = cnt_q - CW'(T_CAC);
  assign beat_valid = col_open && (cnt_q >= CW'(T_CAC));
  assign beat_bank  = beat_idx[BANK_W-1:0];
  assign done       = (st_q == S_DONE);
  assign busy       = (st_q != S_IDLE);

  always_comb begin
    mem_addr = '0;
    if (st_q == S_RAS)                        mem_addr = MA_W'(row_q);
    else if (st_q == S_BURST || st_q == S_PCH) mem_addr = MA_W'(col_q);
  end

  assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && !busy));
  assert_cas_under_ras_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cas_n != '1) |-> (ras_n == '0));
  assert_busy_ignores_req_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && req_valid) |=> $stable(row_q));
endmodule

// File: rtl/linefill_ctrl.sv
module linefill_ctrl
  import lf_pkg::*;
#(
  parameter int ROW_W = 10,
  parameter int COL_W = 10,
  parameter int T_RAC = 3,
  parameter int T_CAC = 2,
  parameter int T_RC  = 8
) (
  input  logic                                 clk,
  input  logic                                rst_n,
  input  logic                                req_valid,
  input  logic [ROW_W+COL_W+BANK_W+OFF_W-1:0] req_addr,
  input  logic                                req_double,
  input  logic                                req_page,
  output logic                                busy,
  output logic [NBANK-1:0]                    ras_n,
  output logic [NBANK-1:0]                    cas_n,
  output logic [((ROW_W > COL_W) ? ROW_W : COL_W)-1:0] mem_addr,
  output logic                                beat_valid,
  output logic [DATA_W-1:0]                   beat_data,
  output logic                                done
);
  localparam int MA_W = (ROW_W > COL_W) ? ROW_W : COL_W;

  logic rst_s1_q, rst_s2_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1_q <= 1'b0;
      rst_s2_q <= 1'b0;
    end else begin
      rst_s1_q <= 1'b1;
      rst_s2_q <= rst_s1_q;
    end
  end

  logic [BANK_W-1:0] beat_bank;
  logic [NBANK-1:0]  bank_ok;
  logic [DATA_W-1:0] bank_data [NBANK];

  lf_sequencer #(
    .ROW_W(ROW_W), .COL_W(COL_W), .MA_W(MA_W),
    .T_RAC(T_RAC), .T_CAC(T_CAC), .T_RC(T_RC)
  ) u_seq (
    .clk        (clk),
    .rst_n      (rst_s2_q),
    .req_valid  (req_valid),
    .req_addr   (req_addr),
    .req_double (req_double),
    .req_page   (req_page),
    .busy       (busy),
    .ras_n      (ras_n),
    .cas_n      (cas_n),
    .mem_addr   (mem_addr),
    .beat_valid (beat_valid),
    .beat_bank  (beat_bank),
    .done       (done)
  );

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    lf_bank #(
      .ROW_W(ROW_W), .COL_W(COL_W), .MA_W(MA_W),
      .T_CAC(T_CAC), .BANK_ID(b)
    ) u_bank (
      .clk      (clk),
      .rst_n    (rst_s2_q),
      .ras_n    (ras_n[b]),
      .cas_n    (cas_n[b]),
      .mem_addr (mem_addr),
      .data_ok  (bank_ok[b]),
      .data     (bank_data[b])
    );
  end

  assign beat_data = beat_valid ? bank_data[beat_bank] : '0;

  assert_beat_from_ready_bank_R5: assert property (@(posedge clk) disable iff (!rst_s2_q)
    beat_valid |-> bank_ok[beat_bank]);
endmodule

// File: tb/sim_linefill_ctrl.sv
module sim_linefill_ctrl;
  localparam int TRAC = 3, TCAC = 2, TRC = 8;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_double, req_page;
  logic [24:0] req_addr;
  logic        busy, beat_valid, done;
  logic [3:0]  ras_n, cas_n;
  logic [9:0]  mem_addr;
  logic [63:0] beat_data;

  always #5 clk = ~clk;

  linefill_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_double(req_double), .req_page(req_page), .busy(busy),
    .ras_n(ras_n), .cas_n(cas_n), .mem_addr(mem_addr),
    .beat_valid(beat_valid), .beat_data(beat_data), .done(done)
  );

  typedef struct {
    bit          busy;
    logic [3:0]  ras, cas;
    bit          achk;
    logic [9:0]  addr;
    bit          bv;
    logic [63:0] data;
    bit          done;
  } rec_t;

  rec_t  q[$];
  int    checks = 0, errors = 0, cycles = 0;
  bit    finished = 0;
  string scen = "R1";

  function automatic rec_t idle_rec();
    rec_t r;
    r.busy = 0; r.ras = 4'hF; r.cas = 4'hF; r.achk = 0; r.addr = '0;
    r.bv = 0; r.data = '0; r.done = 0;
    return r;
  endfunction

  function automatic logic [63:0] word_for(logic [9:0] row, logic [9:0] col, int bank);
    logic [31:0] a;
    a = {7'd0, row, col, bank[1:0], 3'd0};
    return {a, a ^ 32'hFFFF_FFFF};
  endfunction

  function automatic void push(bit rlow, bit clow, bit achk, logic [9:0] ad,
                               bit bv, logic [63:0] dt, bit dn);
    rec_t r;
    r.busy = 1; r.ras = rlow ? 4'h0 : 4'hF; r.cas = clow ? 4'h0 : 4'hF;
    r.achk = achk; r.addr = ad; r.bv = bv; r.data = bv ? dt : '0; r.done = dn;
    q.push_back(r);
  endfunction

  function automatic void burst(logic [9:0] row, logic [9:0] col);
    for (int k = 0; k < TCAC + 4; k++)
      push(1, 1, 1, col, k >= TCAC, word_for(row, col, k - TCAC), 0);
  endfunction

  function automatic void build(logic [24:0] a, bit dbl, bit pg);
    logic [9:0] row, col;
    int gap;
    row = a[24:15];
    col = a[14:5];
    if (dbl) col[0] = 1'b0;
    for (int k = 0; k < TRAC - TCAC; k++) push(1, 0, 1, row, 0, '0, 0);
    burst(row, col);
    if (dbl) begin
      col[0] = 1'b1;
      if (pg) begin
        push(1, 0, 1, col, 0, '0, 0);
        burst(row, col);
      end else begin
        gap = (TRC - TRAC - 4 > 1) ? TRC - TRAC - 4 : 1;
        for (int k = 0; k < gap; k++) push(0, 0, 0, '0, 0, '0, 0);
        for (int k = 0; k < TRAC - TCAC; k++) push(1, 0, 1, row, 0, '0, 0);
        burst(row, col);
      end
    end
    push(0, 0, 0, '0, 0, '0, 1);
  endfunction

  task automatic chk(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s (%s) cycle %0d actual %h expected %h", req, scen, cycles, act, exp);
    end
  endtask

  bit cur_idle;
  task automatic compare();
    rec_t e;
    e = (q.size() > 0) ? q.pop_front() : idle_rec();
    cur_idle = !e.busy;
    chk(busy === e.busy, "R9 busy", 64'(busy), 64'(e.busy));
    chk(ras_n === e.ras, "R3 ras_n", 64'(ras_n), 64'(e.ras));
    chk(cas_n === e.cas, "R4 cas_n", 64'(cas_n), 64'(e.cas));
    if (e.achk) chk(mem_addr === e.addr, "R2 mem_addr", 64'(mem_addr), 64'(e.addr));
    chk(beat_valid === e.bv, "R5 beat_valid", 64'(beat_valid), 64'(e.bv));
    chk(beat_data === e.data, "R5 beat_data", beat_data, e.data);
    chk(done === e.done, "R6 done", 64'(done), 64'(e.done));
  endtask

  task automatic step(bit v, logic [24:0] a, bit d, bit p);
    @(negedge clk);
    compare();
    req_valid = v; req_addr = a; req_double = d; req_page = p;
    if (v && cur_idle && rst_n) build(a, d, p);
  endtask

  task automatic fill(logic [24:0] a, bit d, bit p);
    step(1, a, d, p);
    while (!cur_idle || q.size() > 0) step(0, '0, 0, 0);
    step(0, '0, 0, 0);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      errors++;
      $display("FAIL watchdog expired at cycle %0d", cycles);
      summary();
    end
  end

  initial begin
    rst_n = 1'b0; req_valid = 0; req_addr = '0; req_double = 0; req_page = 0;
    scen = "R1";
    for (int i = 0; i < 3; i++) step(1, 25'h1FFFFFF, 0, 0);
    rst_n = 1'b1;
    for (int i = 0; i < 5; i++) step(0, '0, 0, 0);

    scen = "R2 short, low bits ignored";  fill(25'h1ABCDE7, 0, 0);
    scen = "R10 page flag on short line"; fill(25'h0345A1F, 0, 1);
    scen = "R7 double without page";      fill(25'h12345C0, 1, 0);
    scen = "R8 double with page";         fill(25'h0F0F0E5, 1, 1);
    scen = "R2 all ones";                 fill(25'h1FFFFFF, 1, 0);
    scen = "R2 all zero";                 fill(25'h0000000, 0, 0);

    scen = "R9 request while busy ignored";
    step(1, 25'h0AAAA00, 1, 0);
    for (int i = 0; i < 6; i++) step(1, 25'h1555540, 0, 1);
    while (!cur_idle || q.size() > 0) step(0, '0, 0, 0);

    scen = "R9 held request reaccepted after done";
    step(1, 25'h0C0FFEE, 0, 0);
    for (int i = 0; i < 12; i++) step(1, 25'h0BEEF40, 1, 1);
    while (!cur_idle || q.size() > 0) step(0, '0, 0, 0);
    step(0, '0, 0, 0);
    summary();
  end
endmodule